// File: doc/BRIEF.md
# Eight-Level Polled Priority Interrupt Controller

This block gathers eight interrupt inputs and ranks them by fixed priority, input 0 highest and input 7 lowest. Software reaches it through a byte-wide register port with one address bit. Address 0 takes commands and returns status. Address 1 holds the interrupt mask. The block keeps three registers: a request register that latches rising input edges, an in-service register for levels being handled, and the mask. A level is handed to software through a poll command. The command-port read that follows the poll returns the winning level and acknowledges it in the same cycle.

A three-word setup sequence loads a vector base and a cascade word. A mode word completes the sequence. The block can be set up as a master, with a slave on input 2, or as a slave. A read-select command chooses whether status reads show pending requests or levels in service. A non-specific end-of-interrupt command retires the most urgent level in service. The register port is a plain strobed bus and is never stalled: each read or write strobe takes effect at the clock edge where it is high. There is no valid/ready handshake because no data stream passes through the block.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are zero, status reads return the request register, and `int_out` is low.
- R2: A command write with bit 4 set (for example 0x11) starts setup. It clears the request and in-service registers, cancels any poll in progress, and selects the request register for status reads. The next three data writes are taken as vector base, cascade word and mode word, in that order. None of them changes the mask.
- R3: Once setup is complete, or before setup has ever started, a data write loads the mask (1 masks an input) and a data read returns it.
- R4: A rising edge on an input sets its request bit. The bit clears when the input is low at a clock edge, or when the level is acknowledged.
- R5: After a poll command (0x0C), the next command read returns bit 7 = 1 and the level in bits [2:0]. That read sets the level's in-service bit and clears its request bit.
- R6: A poll that finds nothing to report returns 0x07 and leaves the in-service register unchanged, so in-service bit 7 stays clear.
- R7: Command 0x0B selects the in-service register for status reads and 0x0A selects the request register. The choice lasts until the next select command or the next setup.
- R8: Command 0x20 clears the lowest-numbered bit that is set in the in-service register.
- R9: A pending level is reported only if it is the lowest-numbered unmasked request and no in-service bit of equal or lower number is set.
- R10: `int_out` is high exactly while a level is reportable under R9.
- R11: Masked inputs still latch request bits but are never reported. Clearing the mask bit makes them reportable.
- R12: `vector_base` shows the stored base byte. `slave_on_in2` shows bit 2 of the stored cascade word (0x04 on a master gives 1, 0x02 on a slave gives 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = command/status, 1 = data/mask |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while `bus_rd` is high, zero otherwise |
| irq_in | input | 8 | Interrupt inputs, synchronous to `clk` |
| int_out | output | 1 | A reportable level exists |
| vector_base | output | 8 | Stored vector base |
| slave_on_in2 | output | 1 | Cascade word marks a slave on input 2 |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle, and that `irq_in` changes only in step with `clk`. The bench meets both by driving every input on the falling edge. Its bus tasks raise exactly one strobe for exactly one cycle. It sets inputs only between bus accesses and waits a full cycle before it reads.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } setup_st_t;

  // top three bits of a command that retires the most urgent in-service level
  localparam logic [2:0] EOI_NS_CODE = 3'b001;
  // bit of the cascade word that marks a slave behind input 2
  localparam int CASC_SLAVE_BIT = 2;
endpackage

// File: rtl/pic_edge_req.sv
module pic_edge_req #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] irr
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      irr    <= (irr | rise) & irq_in & ~clr;
    end
  end
endmodule

// File: rtl/pic_first_set.sv
module pic_first_set #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            int_out,
  output logic [DW-1:0]   vector_base,
  output logic            slave_on_in2
);
  localparam int LW   = $clog2(N_IN);
  localparam int PADW = DW - 1 - LW;

  setup_st_t       st_q;
  logic [N_IN-1:0] mask_q;
  logic [N_IN-1:0] isr_q;
  logic [N_IN-1:0] irr;
  logic            sel_isr_q;
  logic            poll_armed_q;
  logic [DW-1:0]   base_q;
  logic            casc2_q;

  logic cmd_wr, dat_wr, cmd_rd, in_run;
  logic setup_start, sel_cmd, eoi_ns;
  logic [N_IN-1:0] pend, ack_vec, eoi_vec, irr_clr;
  logic            pend_found, isr_found, report, poll_ack;
  logic [LW-1:0]   pend_idx, isr_idx;
  logic [DW-1:0]   poll_byte;

  assign cmd_wr = bus_wr & ~bus_addr;
  assign dat_wr = bus_wr & bus_addr;
  assign cmd_rd = bus_rd & ~bus_addr;
  assign in_run = (st_q == ST_RUN);

  assign setup_start = cmd_wr & bus_wdata[4];
  assign sel_cmd     = cmd_wr & in_run & ~bus_wdata[4] & bus_wdata[3];
  assign eoi_ns      = cmd_wr & in_run & ~bus_wdata[4] & ~bus_wdata[3]
                     & (bus_wdata[7:5] == EOI_NS_CODE);

  assign pend = irr & ~mask_q;

  pic_first_set #(.N(N_IN)) u_pend_pick (.vec(pend),  .found(pend_found), .idx(pend_idx));
  pic_first_set #(.N(N_IN)) u_isr_pick  (.vec(isr_q), .found(isr_found),  .idx(isr_idx));

  assign report   = pend_found & (~isr_found | (pend_idx < isr_idx));
  assign int_out  = report;
  assign poll_ack = cmd_rd & poll_armed_q & report;
  assign ack_vec  = poll_ack ? (N_IN'(1) << pend_idx) : '0;
  assign eoi_vec  = (eoi_ns & isr_found) ? (N_IN'(1) << isr_idx) : '0;
  assign irr_clr  = ack_vec | {N_IN{setup_start}};

  pic_edge_req #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(irr_clr), .irr(irr)
  );

  assign poll_byte = report ? {1'b1, {PADW{1'b0}}, pend_idx} : DW'(N_IN - 1);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr)          bus_rdata = DW'(mask_q);
      else if (poll_armed_q) bus_rdata = poll_byte;
      else if (sel_isr_q)    bus_rdata = DW'(isr_q);
      else                   bus_rdata = DW'(irr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      mask_q       <= '1;
      sel_isr_q    <= 1'b0;
      poll_armed_q <= 1'b0;
      base_q       <= '0;
      casc2_q      <= 1'b0;
    end else if (setup_start) begin
      st_q         <= ST_BASE;
      sel_isr_q    <= 1'b0;
      poll_armed_q <= 1'b0;
    end else begin
      if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin base_q  <= bus_wdata;                 st_q <= ST_CASC; end
          ST_CASC: begin casc2_q <= bus_wdata[CASC_SLAVE_BIT]; st_q <= ST_MODE; end
          ST_MODE: st_q <= ST_RUN;
          default: mask_q <= bus_wdata[N_IN-1:0];
        endcase
      end
      if (sel_cmd) begin
        if (bus_wdata[2]) poll_armed_q <= 1'b1;
        if (bus_wdata[1]) sel_isr_q    <= bus_wdata[0];
      end
      if (cmd_rd) poll_armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           isr_q <= '0;
    else if (setup_start) isr_q <= '0;
    else                  isr_q <= (isr_q | ack_vec) & ~eoi_vec;
  end

  assign vector_base  = base_q;
  assign slave_on_in2 = casc2_q;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [N_IN-1:0] irq_in,
  input logic            int_out,
  input logic [N_IN-1:0] mask_q,
  input logic [N_IN-1:0] isr_q,
  input logic [N_IN-1:0] irr,
  input logic            poll_armed_q,
  input logic            in_run
);
  a_bus_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '1) && (isr_q == '0) && (irr == '0));

  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && in_run) |=> mask_q == $past(bus_wdata[N_IN-1:0]));

  a_r4_low_input_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irr & ~$past(irq_in)) == '0));

  a_r5_poll_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && poll_armed_q && int_out)
      |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  a_r6_empty_poll_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && poll_armed_q && !int_out) |=> $stable(isr_q));

  a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && in_run && bus_wdata == 8'h20 && isr_q != '0)
      |=> $countones(isr_q) == $past($countones(isr_q)) - 1);

  a_r10_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask_q) != '0));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_in(irq_in),
  .int_out(int_out), .mask_q(mask_q), .isr_q(isr_q), .irr(irr),
  .poll_armed_q(poll_armed_q), .in_run(in_run)
);

// File: tb/pic_ctrl_bench.sv
`timescale 1ns/1ps
module pic_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out, slave_on_in2;
  logic [7:0] vector_base;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pic_ctrl u_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .int_out(int_out), .vector_base(vector_base),
    .slave_on_in2(slave_on_in2)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic poll_expect(input string req, input logic [7:0] exp);
    logic [7:0] d;
    wr(1'b0, 8'h0C); rd(1'b0, d); chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
    chk("R1 int", {7'b0, int_out}, 8'h00);
  endtask

  task automatic t_setup_master();
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R12 base", vector_base, 8'h00);
    chk("R12 cascade", {7'b0, slave_on_in2}, 8'h01);
    rd(1'b1, d); chk("R2 mask kept", d, 8'hFF);
    wr(1'b1, 8'h00); rd(1'b1, d); chk("R3 mask rw", d, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    set_irq(8'h08);
    rd(1'b0, d); chk("R4 latch", d, 8'h08);
    chk("R10 int high", {7'b0, int_out}, 8'h01);
    set_irq(8'h00);
    rd(1'b0, d); chk("R4 fall clears", d, 8'h00);
    chk("R10 int low", {7'b0, int_out}, 8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    set_irq(8'h28);
    poll_expect("R5 R9 poll level 3", 8'h83);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 isr set", d, 8'h08);
    rd(1'b0, d); chk("R7 select persists", d, 8'h08);
    chk("R9 blocked by isr", {7'b0, int_out}, 8'h00);
    poll_expect("R6 empty poll", 8'h07);
    rd(1'b0, d); chk("R6 isr unchanged", d, 8'h08);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 eoi", d, 8'h00);
    chk("R10 int after eoi", {7'b0, int_out}, 8'h01);
    poll_expect("R5 poll level 5", 8'h85);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R5 irr cleared", d, 8'h00);
    wr(1'b0, 8'h20); set_irq(8'h00);
  endtask

  task automatic t_nested_eoi();
    logic [7:0] d;
    set_irq(8'h40); poll_expect("R5 level 6", 8'h86);
    set_irq(8'h42);
    chk("R9 higher preempts", {7'b0, int_out}, 8'h01);
    poll_expect("R9 level 1", 8'h81);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 two in service", d, 8'h42);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 clears lowest number", d, 8'h40);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 second eoi", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b1, 8'h10); set_irq(8'h10);
    chk("R11 masked no int", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R11 still latched", d, 8'h10);
    poll_expect("R11 masked poll", 8'h07);
    wr(1'b1, 8'h00);
    chk("R11 unmask int", {7'b0, int_out}, 8'h01);
    poll_expect("R11 unmasked poll", 8'h84);
    wr(1'b0, 8'h20); set_irq(8'h00);
  endtask

  task automatic t_level7();
    logic [7:0] d;
    set_irq(8'h80); poll_expect("R5 level 7", 8'h87);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R6 real level 7 in service", d, 8'h80);
    wr(1'b0, 8'h20); set_irq(8'h00);
  endtask

  task automatic t_setup_slave();
    logic [7:0] d;
    set_irq(8'h20);
    wr(1'b0, 8'h11);
    rd(1'b0, d); chk("R2 setup clears irr, selects irr", d, 8'h00);
    wr(1'b1, 8'h08); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    chk("R12 slave base", vector_base, 8'h08);
    chk("R12 slave cascade", {7'b0, slave_on_in2}, 8'h00);
    rd(1'b1, d); chk("R2 mask untouched", d, 8'h00);
    set_irq(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_master();
    t_edge();
    t_poll();
    t_nested_eoi();
    t_mask();
    t_level7();
    t_setup_slave();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule